// File: doc/BRIEF.md
# Masked Interrupt Prioritizer

This block gathers fifteen active-low interrupt sources, numbered 1 to 15, and turns them into one active-low request line for a processor. It also produces a binary code that names the lowest-numbered source that is both asserting and armed. Every source pin first passes through a resynchronising register chain. After that chain it is qualified by a per-source arm bit, and only then does it reach the request and code logic.

Software reaches the block through single-bit accesses at bit addresses. A write to address n, for n from 1 to 15, sets or clears the arm bit of source n. A read at the same addresses does not return the arm bits, so the arm bits cannot be read back. A read at address n, for n from 1 to 14, returns the resynchronised pin level of source n. A read at address 15 returns the current state of the request line.

An internal timer may raise an active-high event, which the block merges onto one chosen source position. Requests are level-sensitive. A source keeps its request active until the source itself releases its pin. Disarming a source only hides it from the request and code logic.

Top module: `irq_prioritizer`

## Requirements
- R1: After reset every arm bit is 0, `req_n_o` is 1 and `code_o` is 0.
- R2: A write with `wr_en_i` high at address n (1 to 15) stores `wr_bit_i` as the arm bit of source n: 1 arms it, 0 blocks it. Writes at address 0 or at 16 to 31 change nothing.
- R3: A read at address n (1 to 14) returns the level of pin n, where 1 means inactive, two clock cycles after the pin changes. It never returns the arm bit.
- R4: A read at address 15 returns the present value of `req_n_o`. A read at address 0 or at 16 to 31 returns 0.
- R5: `req_n_o` goes to 0 exactly when at least one armed source is active. It follows a pin change on the third rising edge after the change, and a write to an arm bit on the second rising edge after the write.
- R6: While `req_n_o` is 0, `code_o` holds the smallest index among the active armed sources. For example, with sources 4 and 7 both active and armed, `code_o` is 4 (0100).
- R7: When no armed source is active, `req_n_o` is 1 and `code_o` is 0.
- R8: Clearing an arm bit blocks its source but does not discard the request. Re-arming the bit while the pin is still low asserts the request again. Releasing the pin removes the request.
- R9: A high `tmr_irq_i` makes source `TIMER_SRC` (default 3) count as active on the next rising edge. Reads of that address still return only the pin level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| int_n_i | input | 15 | Source pins 1..15, active low |
| tmr_irq_i | input | 1 | Timer event, active high, merged onto source TIMER_SRC |
| wr_en_i | input | 1 | Single-bit write strobe |
| wr_addr_i | input | 5 | Bit address of the write |
| wr_bit_i | input | 1 | Bit value to write |
| rd_addr_i | input | 5 | Bit address of the read |
| rd_bit_o | output | 1 | Read data, combinational from `rd_addr_i` |
| req_n_o | output | 1 | Interrupt request, active low, registered |
| code_o | output | 4 | Index of the lowest active armed source, 0 when idle |

## Verification
Each result has a fixed latency, counted from the clock cycle in which the stimulus is driven:

- A pin change reaches `req_n_o` and `code_o` three rising edges later, after two resynchronising stages and the output register.
- An arm-bit write reaches those outputs two edges later.
- A timer event reaches them one edge later.
- A pin level becomes visible to reads two edges after the change, and a read answer is valid in the cycle after the address is set.

The driver records the due cycle with every expected item it pushes. The monitor compares each item only in that exact cycle, sampling between the clock edges, and counts an item that is missed or late as a failure. Between stimuli the driver waits long enough that no two pending results overlap.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    // Source of the value returned on the read port.
    typedef enum logic [1:0] {
        RD_ZERO = 2'd0,
        RD_PIN  = 2'd1,
        RD_REQ  = 2'd2
    } rd_src_e;

    // Classify a read address for a block with num_src sources.
    // Address num_src returns the request state; 1..num_src-1 return pins.
    function automatic rd_src_e classify_rd(input int unsigned addr,
                                            input int unsigned num_src);
        if (addr == num_src)
            return RD_REQ;
        else if (addr >= 1 && addr < num_src)
            return RD_PIN;
        else
            return RD_ZERO;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int unsigned WIDTH  = 15,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    // Resynchronising chain; resets to the inactive (high) level.
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '1;
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int unsigned NUM_SRC = 15,
    parameter int unsigned CODE_W  = 4
) (
    input  logic [NUM_SRC:1]   pend_i,
    output logic [CODE_W-1:0]  code_o,
    output logic               any_o
);
    // Lowest index wins: scan from the top so the last hit is the smallest.
    always_comb begin
        code_o = '0;
        for (int i = NUM_SRC; i >= 1; i--) begin
            if (pend_i[i]) code_o = CODE_W'(i);
        end
        any_o = |pend_i;
    end
endmodule

// File: rtl/irq_prioritizer.sv
module irq_prioritizer
    import irq_prio_pkg::*;
#(
    parameter int unsigned NUM_SRC     = 15,
    parameter int unsigned ADDR_W      = 5,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned TIMER_SRC   = 3,
    localparam int unsigned CODE_W     = $clog2(NUM_SRC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SRC:1]  int_n_i,
    input  logic              tmr_irq_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic              wr_bit_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic              rd_bit_o,
    output logic              req_n_o,
    output logic [CODE_W-1:0] code_o
);

    typedef struct packed {
        logic [NUM_SRC:1]  arm;
        logic              req_n;
        logic [CODE_W-1:0] code;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_SRC:1]  lvl_n;      // resynchronised pin levels
    logic [NUM_SRC:1]  tmr_vec;    // timer event placed on its source slot
    logic [NUM_SRC:1]  pend;       // active and armed
    logic [CODE_W-1:0] enc_code;
    logic              enc_any;

    irq_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (int_n_i),
        .sync_o  (lvl_n)
    );

    generate
        if (TIMER_SRC >= 1 && TIMER_SRC <= NUM_SRC) begin : g_tmr
            assign tmr_vec = {{(NUM_SRC-1){1'b0}}, tmr_irq_i} << (TIMER_SRC - 1);
        end else begin : g_no_tmr
            assign tmr_vec = '0;
        end
    endgenerate

    assign pend = (~lvl_n | tmr_vec) & st_q.arm;

    irq_prio_enc #(.NUM_SRC(NUM_SRC), .CODE_W(CODE_W)) u_enc (
        .pend_i (pend),
        .code_o (enc_code),
        .any_o  (enc_any)
    );

    // Next-state computation.
    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            for (int i = 1; i <= NUM_SRC; i++) begin
                if (wr_addr_i == ADDR_W'(i)) st_d.arm[i] = wr_bit_i;
            end
        end
        st_d.req_n = ~enc_any;
        st_d.code  = enc_code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.arm   <= '0;
            st_q.req_n <= 1'b1;
            st_q.code  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Read port: pin levels or request state, never the arm bits.
    always_comb begin
        rd_bit_o = 1'b0;
        unique case (classify_rd(int'(rd_addr_i), NUM_SRC))
            RD_REQ: rd_bit_o = st_q.req_n;
            RD_PIN: begin
                for (int i = 1; i < NUM_SRC; i++) begin
                    if (rd_addr_i == ADDR_W'(i)) rd_bit_o = lvl_n[i];
                end
            end
            default: rd_bit_o = 1'b0;
        endcase
    end

    assign req_n_o = st_q.req_n;
    assign code_o  = st_q.code;

    // Idle outputs carry code 0 (R7).
    p_idle_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_n_o |-> (code_o == '0));

    // An asserted request always names a real source (R6).
    p_code_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_n_o |-> (code_o != '0));

    // No pending source in a cycle means no request after the next edge (R5).
    p_no_pend_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |=> req_n_o);

    // Arm bits only move on a write strobe (R2).
    p_arm_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(st_q.arm));

    // Writes outside the arm range leave every arm bit untouched (R2).
    p_arm_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (wr_addr_i == '0 || int'(wr_addr_i) > NUM_SRC)) |=> $stable(st_q.arm));

    // At most one bit of the arm vector changes per write (R2).
    p_arm_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> $onehot0(st_q.arm ^ $past(st_q.arm)));

endmodule

// File: tb/tb_irq_prioritizer.sv
module tb_irq_prioritizer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:1] int_n = '1;
    logic        tmr = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic        wr_bit = 1'b0;
    logic [4:0]  rd_addr = '0;
    logic        rd_bit;
    logic        req_n;
    logic [3:0]  code;

    always #2.5 clk = ~clk;

    irq_prioritizer dut (
        .clk(clk), .rst_n(rst_n), .int_n_i(int_n), .tmr_irq_i(tmr),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_bit_i(wr_bit),
        .rd_addr_i(rd_addr), .rd_bit_o(rd_bit), .req_n_o(req_n), .code_o(code)
    );

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Reference model state.
    logic [15:1] m_arm = '0;

    typedef struct {
        int         due;
        bit         is_rd;
        logic       exp_rd;
        logic       exp_req;
        logic [3:0] exp_code;
        string      tag;
    } item_t;

    item_t sb[$];

    function automatic logic [15:1] m_pend();
        logic [15:1] act;
        act = ~int_n;
        act[3] = act[3] | tmr;
        return act & m_arm;
    endfunction

    function automatic logic [3:0] m_code();
        logic [15:1] p;
        p = m_pend();
        for (int i = 15; i >= 1; i--) if (p[i]) m_code = 4'(i);
        if (p == '0) m_code = 4'd0;
    endfunction

    function automatic logic m_req();
        return (m_pend() == '0);
    endfunction

    task automatic push_out(input int lat, input string tag);
        item_t it;
        it.due = cyc + lat; it.is_rd = 1'b0; it.exp_rd = 1'b0;
        it.exp_req = m_req(); it.exp_code = m_code(); it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: compare items exactly in their due cycle, between edges.
    always @(posedge clk) begin
        #2;
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (it.due != cyc) begin
                errors++;
                $display("FAIL %s: item due %0d seen at %0d", it.tag, it.due, cyc);
            end else if (it.is_rd) begin
                if (rd_bit !== it.exp_rd) begin
                    errors++;
                    $display("FAIL %s: rd_bit=%b expected %b", it.tag, rd_bit, it.exp_rd);
                end
            end else if (req_n !== it.exp_req || code !== it.exp_code) begin
                errors++;
                $display("FAIL %s: req_n=%b code=%0d expected req_n=%b code=%0d",
                         it.tag, req_n, code, it.exp_req, it.exp_code);
            end
        end
    end

    task automatic set_pins(input logic [15:1] v, input string tag);
        int_n = v;
        push_out(3, tag);
        repeat (4) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic b, input string tag);
        wr_en = 1'b1; wr_addr = 5'(a); wr_bit = b;
        if (a >= 1 && a <= 15) m_arm[a] = b;
        push_out(2, tag);
        @(negedge clk);
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic set_tmr(input logic v, input string tag);
        tmr = v;
        push_out(1, tag);
        repeat (3) @(negedge clk);
    endtask

    task automatic rd(input int a, input logic exp, input string tag);
        item_t it;
        rd_addr = 5'(a);
        it.due = cyc + 1; it.is_rd = 1'b1; it.exp_rd = exp;
        it.exp_req = 1'b0; it.exp_code = '0; it.tag = tag;
        sb.push_back(it);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        checks++;
        if (req_n !== 1'b1 || code !== 4'd0) begin
            errors++;
            $display("FAIL R1: req_n=%b code=%0d expected 1/0", req_n, code);
        end

        rd(5, 1'b1, "R3 pin5 idle level, arm bit 0");
        wr(4, 1'b1, "R7 arm 4 with pin high stays idle");
        set_pins(15'h7FFF & ~(15'h1 << 3), "R5 pin4 low armed");
        wr(7, 1'b1, "R2 arm 7");
        set_pins(15'h7FFF & ~(15'h1 << 3) & ~(15'h1 << 6), "R6 4 and 7 gives 4");
        wr(4, 1'b0, "R8 block 4 leaves 7");
        wr(4, 1'b1, "R8 rearm 4 with pin still low");
        set_pins(15'h7FFF & ~(15'h1 << 6), "R8 release 4 leaves 7");
        set_pins(15'h7FFF, "R7 all released idle");
        wr(0, 1'b1, "R2 write addr 0 ignored");
        wr(20, 1'b1, "R2 write addr 20 ignored");
        wr(2, 1'b1, "R2 arm 2");
        set_pins(15'h7FFF & ~15'h2, "R5 pin2 low");
        rd(2, 1'b0, "R3 pin2 low read");
        rd(15, 1'b0, "R4 read 15 is request");
        rd(0, 1'b0, "R4 read 0 is zero");
        rd(20, 1'b0, "R4 read 20 is zero");
        wr(15, 1'b1, "R2 arm 15");
        wr(1, 1'b1, "R2 arm 1");
        set_pins(15'h7FFF & ~(15'h1 << 14), "R6 only 15 low gives 15");
        set_pins(15'h7FFF & ~(15'h1 << 14) & ~15'h1, "R6 1 and 15 gives 1");
        set_pins(15'h7FFF, "R7 idle again");
        rd(15, 1'b1, "R4 read 15 idle");
        wr(3, 1'b1, "R9 arm timer slot");
        set_tmr(1'b1, "R9 timer event on 3");
        rd(3, 1'b1, "R9 read 3 shows pin only");
        set_tmr(1'b0, "R9 timer removed");

        repeat (5) @(negedge clk);
        done = 1'b1;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule